// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive request lines and presents them to a processor as two outputs, a normal interrupt line and a fast interrupt line. A per-source routing mask picks which output a source drives, and an enable mask, changed only through separate set and clear registers, gates every source. Software may force any request through a software-set register and withdraw it through a software-clear register.

On top of the normal-interrupt path sit sixteen vector slots in strict priority order, slot 0 highest. Each slot binds one source number to a 32-bit handler address. A handler reads the current-vector register to claim the winning request and get its address, then writes that register with any value when it finishes. Claims nest: while a slot is in service only higher-priority slots can be claimed, and each acknowledge retires the highest-priority entry still in service. A request that no enabled slot covers is served through a default address.

All access goes through a simple single-cycle register port: word-addressed, write on a strobe, read data combinational from address.

Top module: `vic_top`

## Requirements
- R1: After a synchronous reset the enable mask, routing mask and software requests read 0, both outputs are low, nothing is in service, and the default address reads 0.
- R2: A write to word 0x04 sets every enable bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged; reading word 0x04 returns the enable mask.
- R3: A write to word 0x05 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R4: Word 0x02 reads the request levels (hardware input OR software request) whatever the enable and routing masks hold.
- R5: Word 0x03 holds the routing mask, a 1 sending that source to the fast line; word 0x00 reads levels AND enable AND NOT routing, word 0x01 reads levels AND enable AND routing, and each output is the OR of its own status word.
- R6: A write to word 0x06 sets software requests for its 1 bits (read back at 0x06); a write to word 0x07 clears them for its 1 bits; zero bits change nothing.
- R7: Words 0x10+i hold the handler address of slot i; words 0x20+i hold its control, bit 5 the slot enable and bits 4:0 the source number; both read back as written.
- R8: A read of word 0x08 returns the address of the lowest-numbered enabled slot whose source is pending on the normal line and whose number is below every slot in service, and marks that slot in service.
- R9: If no enabled slot matches any pending normal-line request, nothing is in service and a request is pending, a read of word 0x08 returns the default address (word 0x09) and marks the default in service; a read with no eligible request returns the default address and claims nothing.
- R10: A write of any value to word 0x08 retires the highest-priority entry in service; with nothing in service it has no effect.
- R11: While a slot is in service, the same or lower-priority slots cannot be claimed but a higher-priority one can, so repeated acknowledges unwind nested claims in priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| src_i | input | 32 | Raw request levels |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The two functions that meet in one cycle are the claim read and a change of the request levels: because the read data is combinational, a source that rises or falls in the very cycle of the vector read decides which address comes back and which slot is marked. The bench drives the new source levels at the same falling edge that presents the read, and judges that the address returned and the next claim both follow the new levels, not the previous ones. Nested claims are also built three deep and then unwound one acknowledge at a time, each stage judged by what the next read returns.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int DW    = 32;
    localparam int NSRC  = 32;
    localparam int NSLOT = 16;
    localparam int SRCW  = $clog2(NSRC);
    localparam int SLOTW = $clog2(NSLOT);
    localparam int AW    = SLOTW + 2;
    localparam int IDXW  = $clog2(DW) + 1;

    // Fixed register words (page 0)
    typedef enum logic [AW-1:0] {
        A_IRQST = 6'h00,
        A_FIQST = 6'h01,
        A_RAW   = 6'h02,
        A_SEL   = 6'h03,
        A_ENSET = 6'h04,
        A_ENCLR = 6'h05,
        A_SWSET = 6'h06,
        A_SWCLR = 6'h07,
        A_VADDR = 6'h08,
        A_DEFV  = 6'h09
    } reg_addr_e;

    localparam logic [AW-SLOTW-1:0] PG_VECT = 2'b01;
    localparam logic [AW-SLOTW-1:0] PG_CTL  = 2'b10;

    typedef struct packed {
        logic            en;
        logic [SRCW-1:0] src;
    } slot_ctl_t;

    // Index of the lowest set bit, DW when none is set.
    function automatic logic [IDXW-1:0] first_one(input logic [DW-1:0] v);
        logic [IDXW-1:0] r;
        r = IDXW'(DW);
        for (int i = DW - 1; i >= 0; i--) begin
            if (v[i]) r = IDXW'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    input  logic [NSRC-1:0]            hw_src,
    output logic [NSRC-1:0]            en_q,
    output logic [NSRC-1:0]            sel_q,
    output logic [NSRC-1:0]            soft_q,
    output logic [NSRC-1:0]            raw,
    output logic [NSLOT-1:0][DW-1:0]   vaddr_q,
    output slot_ctl_t [NSLOT-1:0]      ctl_q,
    output logic [DW-1:0]              dflt_q
);
    logic [NSRC-1:0] wbits;
    logic [AW-SLOTW-1:0] page;
    logic [SLOTW-1:0]    slot;

    assign wbits = wdata[NSRC-1:0];
    assign page  = addr[AW-1:SLOTW];
    assign slot  = addr[SLOTW-1:0];
    assign raw   = hw_src | soft_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            sel_q   <= '0;
            soft_q  <= '0;
            dflt_q  <= '0;
            vaddr_q <= '0;
            ctl_q   <= '0;
        end else if (wr_en) begin
            if (page == PG_VECT) begin
                vaddr_q[slot] <= wdata;
            end else if (page == PG_CTL) begin
                ctl_q[slot] <= slot_ctl_t'(wdata[SRCW:0]);
            end else begin
                case (addr)
                    A_SEL:   sel_q  <= wbits;
                    A_ENSET: en_q   <= en_q | wbits;
                    A_ENCLR: en_q   <= en_q & ~wbits;
                    A_SWSET: soft_q <= soft_q | wbits;
                    A_SWCLR: soft_q <= soft_q & ~wbits;
                    A_DEFV:  dflt_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    p_enset_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_ENSET) |=>
        ((en_q & $past(wbits)) == $past(wbits)) &&
        ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));

    p_enclr_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_ENCLR) |=>
        ((en_q & $past(wbits)) == '0) &&
        ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));

    p_swclr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_SWCLR) |=> ((soft_q & $past(wbits)) == '0));
endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       irq_st,
    input  slot_ctl_t [NSLOT-1:0] ctl,
    input  logic                  claim,
    input  logic                  ack,
    output logic                  slot_hit,
    output logic [SLOTW-1:0]      win
);
    // bit NSLOT marks the default vector in service
    logic [NSLOT:0]     isr_q;
    logic [NSLOT-1:0]   act, elig;
    logic [IDXW-1:0]    lvl, win_full;
    logic               dflt_take;

    assign lvl = first_one({{(DW-NSLOT-1){1'b0}}, isr_q});

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign act[i]  = ctl[i].en & irq_st[ctl[i].src];
        assign elig[i] = act[i] && (IDXW'(i) < lvl);
    end

    assign win_full  = first_one({{(DW-NSLOT){1'b0}}, elig});
    assign win       = win_full[SLOTW-1:0];
    assign slot_hit  = |elig;
    assign dflt_take = (|irq_st) & ~(|act) & (isr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
        end else if (claim && slot_hit) begin
            for (int k = 0; k < NSLOT; k++)
                if (win == SLOTW'(k)) isr_q[k] <= 1'b1;
        end else if (claim && dflt_take) begin
            isr_q[NSLOT] <= 1'b1;
        end else if (ack && (isr_q != '0)) begin
            for (int k = 0; k <= NSLOT; k++)
                if (lvl == IDXW'(k)) isr_q[k] <= 1'b0;
        end
    end

    p_claim_push_r8: assert property (@(posedge clk) disable iff (rst)
        (claim && (slot_hit || dflt_take)) |=>
        ($countones(isr_q) == $past($countones(isr_q)) + 1));

    p_ack_pop_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && (isr_q != '0)) |=>
        ($countones(isr_q) + 1 == $past($countones(isr_q))));

    p_ack_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && (isr_q == '0)) |=> (isr_q == '0));

    p_nest_top_r11: assert property (@(posedge clk) disable iff (rst)
        (claim && slot_hit) |=> (lvl == IDXW'($past(win))));
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_i,
    output logic            irq_o,
    output logic            fiq_o
);
    logic [NSRC-1:0]          en_q, sel_q, soft_q, raw, irq_st, fiq_st;
    logic [NSLOT-1:0][DW-1:0] vaddr_q;
    slot_ctl_t [NSLOT-1:0]    ctl_q;
    logic [DW-1:0]            dflt_q;
    logic                     slot_hit, claim, ack;
    logic [SLOTW-1:0]         win;

    assign claim = bus_en & ~bus_we & (bus_addr == A_VADDR);
    assign ack   = bus_en &  bus_we & (bus_addr == A_VADDR);

    vic_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_en & bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .hw_src(src_i), .en_q(en_q), .sel_q(sel_q),
        .soft_q(soft_q), .raw(raw), .vaddr_q(vaddr_q), .ctl_q(ctl_q),
        .dflt_q(dflt_q)
    );

    assign irq_st = raw & en_q & ~sel_q;
    assign fiq_st = raw & en_q & sel_q;
    assign irq_o  = |irq_st;
    assign fiq_o  = |fiq_st;

    vic_prio u_prio (
        .clk(clk), .rst(rst), .irq_st(irq_st), .ctl(ctl_q),
        .claim(claim), .ack(ack), .slot_hit(slot_hit), .win(win)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[AW-1:SLOTW] == PG_VECT) begin
            bus_rdata = vaddr_q[bus_addr[SLOTW-1:0]];
        end else if (bus_addr[AW-1:SLOTW] == PG_CTL) begin
            bus_rdata = {{(DW-SRCW-1){1'b0}}, ctl_q[bus_addr[SLOTW-1:0]]};
        end else begin
            case (bus_addr)
                A_IRQST: bus_rdata = DW'(irq_st);
                A_FIQST: bus_rdata = DW'(fiq_st);
                A_RAW:   bus_rdata = DW'(raw);
                A_SEL:   bus_rdata = DW'(sel_q);
                A_ENSET: bus_rdata = DW'(en_q);
                A_SWSET: bus_rdata = DW'(soft_q);
                A_VADDR: bus_rdata = slot_hit ? vaddr_q[win] : dflt_q;
                A_DEFV:  bus_rdata = dflt_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] src = '0;
    logic        irq_o, fiq_o;
    int          n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    vic_top dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_i(src), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_src(input logic [5:0] a, input logic [31:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; src = s;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_src(a, src, d);
    endtask

    task automatic lines(input string tag, input logic ei, input logic ef);
        @(negedge clk); #1;
        chk({tag, " irq_o"}, {31'b0, irq_o}, {31'b0, ei});
        chk({tag, " fiq_o"}, {31'b0, fiq_o}, {31'b0, ef});
    endtask

    function automatic logic [31:0] va(input int i);
        return 32'h1000_0000 + i * 32'h40;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(6'h04, d); chk("R1 enable", d, 0);
        rd(6'h03, d); chk("R1 select", d, 0);
        rd(6'h06, d); chk("R1 soft", d, 0);
        rd(6'h09, d); chk("R1 default", d, 0);
        lines("R1", 1'b0, 1'b0);

        // R4 raw levels visible with everything disabled
        src = 32'hA5A5_0F0F;
        rd(6'h02, d); chk("R4 raw", d, 32'hA5A5_0F0F);
        rd(6'h00, d); chk("R4 masked irq zero", d, 0);
        lines("R4", 1'b0, 1'b0);

        // R2/R3 zero bits leave others alone
        wr(6'h04, 32'h0000_00F0); wr(6'h04, 32'h0000_000F);
        rd(6'h04, d); chk("R2 set accum", d, 32'h0000_00FF);
        wr(6'h05, 32'h0000_003C);
        rd(6'h04, d); chk("R3 clear partial", d, 32'h0000_00C3);
        wr(6'h05, 32'hFFFF_FFFF);
        rd(6'h04, d); chk("R3 clear all", d, 0);

        // R2/R3/R5 sweep over every source
        for (int s = 0; s < 32; s++) begin
            logic [31:0] b;
            b = 32'h1 << s;
            src = b;
            wr(6'h04, b);
            rd(6'h00, d); chk("R2 irq status", d, b);
            rd(6'h01, d); chk("R5 fiq status idle", d, 0);
            lines("R5 irq route", 1'b1, 1'b0);
            wr(6'h03, b);
            rd(6'h01, d); chk("R5 fiq status", d, b);
            rd(6'h00, d); chk("R5 irq status routed away", d, 0);
            lines("R5 fiq route", 1'b0, 1'b1);
            wr(6'h03, 32'h0);
            wr(6'h05, b);
            rd(6'h00, d); chk("R3 disabled", d, 0);
            lines("R3 lines", 1'b0, 1'b0);
        end

        // R6 software requests
        src = 32'h0;
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h06, 32'h0000_8001);
        rd(6'h02, d); chk("R6 raw soft", d, 32'h0000_8001);
        lines("R6 soft irq", 1'b1, 1'b0);
        wr(6'h07, 32'h0000_0001);
        rd(6'h06, d); chk("R6 soft clear one", d, 32'h0000_8000);
        wr(6'h07, 32'h0);
        rd(6'h06, d); chk("R6 soft clear zero", d, 32'h0000_8000);
        wr(6'h07, 32'hFFFF_FFFF);
        rd(6'h02, d); chk("R6 raw cleared", d, 0);
        lines("R6 idle", 1'b0, 1'b0);

        // R7 slot tables
        for (int i = 0; i < 16; i++) begin
            wr(6'h10 + 6'(i), va(i));
            wr(6'h20 + 6'(i), 32'h0000_0020 | 32'((i * 7 + 3) % 32));
        end
        for (int i = 0; i < 16; i++) begin
            rd(6'h10 + 6'(i), d); chk("R7 vector addr", d, va(i));
            rd(6'h20 + 6'(i), d); chk("R7 vector ctl", d, 32'h20 | 32'((i * 7 + 3) % 32));
            wr(6'h20 + 6'(i), 32'((i * 7 + 3) % 32));
        end
        wr(6'h09, 32'hDEAD_0000);

        // R8 sweep: each slot alone
        for (int i = 0; i < 16; i++) begin
            int s;
            s = (i * 7 + 3) % 32;
            wr(6'h20 + 6'(i), 32'h20 | 32'(s));
            src = 32'h1 << s;
            rd(6'h08, d); chk("R8 claim slot", d, va(i));
            rd(6'h08, d); chk("R11 same slot blocked", d, 32'hDEAD_0000);
            wr(6'h08, 32'h0);
            rd(6'h08, d); chk("R10 reclaim after ack", d, va(i));
            wr(6'h08, 32'h0);
            wr(6'h20 + 6'(i), 32'h0);
        end
        src = 32'h0;

        // R11 nested priority: slot3->src10, slot7->src20, slot1->src2
        wr(6'h23, 32'h20 | 32'd10);
        wr(6'h27, 32'h20 | 32'd20);
        wr(6'h21, 32'h20 | 32'd2);
        src = (32'h1 << 10) | (32'h1 << 20);
        rd(6'h08, d); chk("R8 highest wins", d, va(3));
        rd(6'h08, d); chk("R11 lower blocked", d, 32'hDEAD_0000);
        // source rises in the same cycle as the claim read
        rd_src(6'h08, src | 32'h4, d); chk("R11 higher claimed same-cycle", d, va(1));
        src = src & ~32'h4;
        wr(6'h08, 32'h0);
        rd(6'h08, d); chk("R11 slot3 still in service", d, 32'hDEAD_0000);
        wr(6'h08, 32'h0);
        rd(6'h08, d); chk("R10 pop to empty", d, va(3));
        wr(6'h08, 32'h0);
        // source falls in the same cycle as the claim read
        rd_src(6'h08, 32'h1 << 20, d); chk("R8 fall same-cycle", d, va(7));

        // three-deep stack: 7 in service, add 3 then 1
        rd_src(6'h08, src | (32'h1 << 10), d); chk("R11 push slot3", d, va(3));
        rd_src(6'h08, src | 32'h4, d); chk("R11 push slot1", d, va(1));
        src = 32'h1 << 20;
        wr(6'h08, 32'h0);
        rd(6'h08, d); chk("R10 unwind 1", d, 32'hDEAD_0000);
        wr(6'h08, 32'h0);
        rd(6'h08, d); chk("R10 unwind 2", d, 32'hDEAD_0000);
        wr(6'h08, 32'h0);
        rd(6'h08, d); chk("R10 unwind 3", d, va(7));
        wr(6'h08, 32'h0);
        // extra acknowledges on an empty stack
        wr(6'h08, 32'h0); wr(6'h08, 32'h0);
        src = 32'h1 << 10;
        rd(6'h08, d); chk("R10 empty ack harmless", d, va(3));
        wr(6'h08, 32'h0);

        // R9 default vector
        wr(6'h23, 32'h0); wr(6'h27, 32'h0); wr(6'h21, 32'h0);
        src = 32'h0;
        rd(6'h08, d); chk("R9 nothing pending", d, 32'hDEAD_0000);
        src = 32'h1 << 4;
        rd(6'h08, d); chk("R9 default claim", d, 32'hDEAD_0000);
        wr(6'h25, 32'h20 | 32'd4);
        rd(6'h08, d); chk("R11 slot above default", d, va(5));
        wr(6'h08, 32'h0);
        wr(6'h25, 32'h0);
        wr(6'h29, 32'h20 | 32'd4);
        wr(6'h08, 32'h0);
        rd(6'h08, d); chk("R9 default retired", d, va(9));
        wr(6'h08, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule